// File: doc/BRIEF.md
# Reload-Counter Timer PWM Generator

This block produces a pulse-width-modulated output from a 32-bit up-counter. The counter does not start over at zero after it passes all-ones: it reloads a programmable start value. The distance from that start value to all-ones sets the period. A second programmable value between the start value and all-ones sets the point where the active pulse ends. The pulse begins when the counter wraps and ends when the counter leaves the compare value.

Software drives the block through a small write port with four word addresses: control, reload value, compare value and live count. It reads the running and polarity bits back on a two-bit status output. A typical start-up stops the counter, programs the reload and compare values, and preloads the count to all-ones minus one. Setting the start bit then puts the first active edge on the second counter tick. An optional prescaler slows the counter tick to a power-of-two fraction of the clock.

Top module: `tpwm_top`

## Requirements
- R1: After reset the output is low, the status output is 0, and the run, polarity, trigger, prescaler, reload, compare and count state is all zero.
- R2: Each tick while running adds one to the count. A tick at all-ones loads the reload value instead of wrapping, so a period lasts (all-ones minus reload plus 1) ticks.
- R3: With trigger code 2, a wrap drives the output to its active level. A tick taken while the count equals the compare value drives it back to inactive. Active time is (compare minus reload plus 1) ticks and inactive time is (all-ones minus compare) ticks.
- R4: A write to the count register (address 3) is in force on the next cycle and overrides any tick in that cycle. Preloading all-ones minus one and then starting gives the first active edge on the second tick.
- R5: The trigger field sits in control bits 3:2. Code 1 inverts the output on every wrap. Code 3 inverts it on every compare tick. Code 0 leaves the output unchanged.
- R6: Control bit 1 inverts the output level. A write to this bit is ignored while the counter is running. The status output carries the running bit in bit 0 and the polarity bit in bit 1.
- R7: Clearing control bit 0 (the start bit) stops the count at once, part way through a period. The output and the count then hold. Setting the bit again resumes counting from the held count.
- R8: Writes to the reload register (address 1) and the compare register (address 2) act at once, with no shadow copy. Raising the compare value during an active phase lengthens that same phase.
- R9: Control bit 4 enables the prescaler. Control bits 7:5 hold n, and the counter then ticks once every 2^(n+1) clocks. With the enable bit clear the counter ticks on every clock.
- R10: The control register is at address 0. Its fields are: start in bit 0, polarity in bit 1, trigger in bits 3:2, prescaler enable in bit 4 and prescaler value in bits 7:5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register word address |
| wr_data_i | input | 32 | Register write data |
| stat_o | output | 2 | Bit 0 running, bit 1 polarity |
| pwm_o | output | 1 | PWM output |

## Verification
The compare mode is run with several reload and compare pairs: a 10-tick period with 3 active ticks, the 2-tick minimum with 1 active tick, and a 5-tick period with the widest legal pulse. These separate an off-by-one at the wrap from one at the compare. The same waveform is repeated with the prescaler at two settings, which shows that the division scales both phases alike. The two single-event toggle codes and the hold code are run on one period so they can be told apart from the compare mode. Preloads to all-ones minus one and minus five time the first edge from the start write. A stop in mid-pulse followed by a restart shows the frozen count. A compare write inside an active phase shows that the write takes effect at once.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;

    // Output trigger selection (control bits 3:2)
    typedef enum logic [1:0] {
        TRG_HOLD = 2'd0,
        TRG_OVF  = 2'd1,
        TRG_PWM  = 2'd2,
        TRG_CMP  = 2'd3
    } trig_e;

    // Register word addresses
    typedef enum logic [1:0] {
        RA_CTRL  = 2'd0,
        RA_LOAD  = 2'd1,
        RA_MATCH = 2'd2,
        RA_COUNT = 2'd3
    } reg_addr_e;

    // Control field positions
    localparam int CTL_RUN = 0;
    localparam int CTL_POL = 1;
    localparam int CTL_TRG = 2;
    localparam int CTL_PSE = 4;
    localparam int CTL_PSV = 5;

endpackage

// File: rtl/tpwm_regs.sv
module tpwm_regs
    import tpwm_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             run,
    output logic             pol,
    output trig_e            trig,
    output logic             psc_en,
    output logic [PSC_W-1:0] psc_sel,
    output logic [CNT_W-1:0] load,
    output logic [CNT_W-1:0] match,
    output logic             cnt_wr
);

    typedef struct packed {
        logic             run;
        logic             pol;
        trig_e            trig;
        logic             psc_en;
        logic [PSC_W-1:0] psc_sel;
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] match;
    } regs_t;

    regs_t r_d, r_q;
    reg_addr_e addr;

    assign addr = reg_addr_e'(wr_addr);

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (addr)
                RA_CTRL: begin
                    r_d.run     = wr_data[CTL_RUN];
                    // polarity is locked while the counter runs
                    if (!r_q.run) begin
                        r_d.pol = wr_data[CTL_POL];
                    end
                    r_d.trig    = trig_e'(wr_data[CTL_TRG +: 2]);
                    r_d.psc_en  = wr_data[CTL_PSE];
                    r_d.psc_sel = wr_data[CTL_PSV +: PSC_W];
                end
                RA_LOAD:  r_d.load  = wr_data;
                RA_MATCH: r_d.match = wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign run     = r_q.run;
    assign pol     = r_q.pol;
    assign trig    = r_q.trig;
    assign psc_en  = r_q.psc_en;
    assign psc_sel = r_q.psc_sel;
    assign load    = r_q.load;
    assign match   = r_q.match;
    assign cnt_wr  = wr_en && (addr == RA_COUNT);

endmodule

// File: rtl/tpwm_prescaler.sv
module tpwm_prescaler #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             en,
    input  logic [PSC_W-1:0] sel,
    output logic             tick
);

    localparam int DIV_W = 2 ** PSC_W;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } psc_t;

    psc_t p_d, p_q;
    logic [DIV_W-1:0] limit;

    // limit = 2^(sel+1) - 1 : low sel+1 bits set
    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            limit[i] = (i <= int'(sel));
        end
    end

    always_comb begin
        tick = run && (!en || (p_q.cnt == limit));
        p_d  = p_q;
        if (!run || !en || tick) begin
            p_d.cnt = '0;
        end else begin
            p_d.cnt = p_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

endmodule

// File: rtl/tpwm_counter.sv
module tpwm_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] load,
    input  logic [CNT_W-1:0] match,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf,
    output logic             cmp
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t c_d, c_q;

    always_comb begin
        ovf = tick && (c_q.cnt == ALL_ONES);
        cmp = tick && (c_q.cnt == match);
        c_d = c_q;
        if (wr) begin
            c_d.cnt = wr_val;
        end else if (ovf) begin
            c_d.cnt = load;
        end else if (tick) begin
            c_d.cnt = c_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cnt = c_q.cnt;

endmodule

// File: rtl/tpwm_outgen.sv
module tpwm_outgen
    import tpwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  trig_e trig,
    input  logic  pol,
    input  logic  ovf,
    input  logic  cmp,
    output logic  raw,
    output logic  pwm
);

    typedef struct packed {
        logic lvl;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d = o_q;
        unique case (trig)
            TRG_OVF: if (ovf) o_d.lvl = ~o_q.lvl;
            TRG_CMP: if (cmp) o_d.lvl = ~o_q.lvl;
            TRG_PWM: begin
                if (ovf) begin
                    o_d.lvl = 1'b1;
                end else if (cmp) begin
                    o_d.lvl = 1'b0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign raw = o_q.lvl;
    assign pwm = o_q.lvl ^ pol;

endmodule

// File: rtl/tpwm_top.sv
module tpwm_top
    import tpwm_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PSC_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [1:0]       stat_o,
    output logic             pwm_o
);

    logic             run;
    logic             pol;
    trig_e            trig;
    logic             psc_en;
    logic [PSC_W-1:0] psc_sel;
    logic [CNT_W-1:0] load;
    logic [CNT_W-1:0] match;
    logic             cnt_wr;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             ovf;
    logic             cmp;
    logic             raw;

    tpwm_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
        .clk     (clk_i),
        .rst_n   (rst_ni),
        .wr_en   (wr_en_i),
        .wr_addr (wr_addr_i),
        .wr_data (wr_data_i),
        .run     (run),
        .pol     (pol),
        .trig    (trig),
        .psc_en  (psc_en),
        .psc_sel (psc_sel),
        .load    (load),
        .match   (match),
        .cnt_wr  (cnt_wr)
    );

    tpwm_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk   (clk_i),
        .rst_n (rst_ni),
        .run   (run),
        .en    (psc_en),
        .sel   (psc_sel),
        .tick  (tick)
    );

    tpwm_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk    (clk_i),
        .rst_n  (rst_ni),
        .tick   (tick),
        .load   (load),
        .match  (match),
        .wr     (cnt_wr),
        .wr_val (wr_data_i),
        .cnt    (cnt),
        .ovf    (ovf),
        .cmp    (cmp)
    );

    tpwm_outgen u_out (
        .clk   (clk_i),
        .rst_n (rst_ni),
        .trig  (trig),
        .pol   (pol),
        .ovf   (ovf),
        .cmp   (cmp),
        .raw   (raw),
        .pwm   (pwm_o)
    );

    assign stat_o = {pol, run};

endmodule

// File: rtl/tpwm_checker.sv
module tpwm_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             pol,
    input logic [1:0]       trig,
    input logic             psc_en,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] load,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] wr_data,
    input logic             ovf,
    input logic             cmp,
    input logic             raw
);

    // R2: a wrap reloads the count from the reload register
    assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !cnt_wr) |=> (cnt == $past(load)));

    // R3: in compare mode the output rises only after a wrap
    assert_rise_on_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(raw) && ($past(trig) == 2'd2)) |-> $past(ovf));

    // R3: in compare mode the output falls only after a compare tick
    assert_fall_on_cmp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(raw) && ($past(trig) == 2'd2)) |-> $past(cmp));

    // R4: a count write lands on the next cycle
    assert_cnt_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(wr_data)));

    // R6: polarity does not move while the counter keeps running
    assert_pol_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(pol));

    // R7: a stopped counter holds its value
    assert_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt));

    // R9: with the prescaler on, ticks never come on back-to-back clocks
    assert_psc_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && psc_en) |=> (!tick || !psc_en));

endmodule

bind tpwm_top tpwm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .run     (run),
    .pol     (pol),
    .trig    (trig),
    .psc_en  (psc_en),
    .tick    (tick),
    .cnt     (cnt),
    .load    (load),
    .cnt_wr  (cnt_wr),
    .wr_data (wr_data_i),
    .ovf     (ovf),
    .cmp     (cmp),
    .raw     (raw)
);

// File: tb/tpwm_top_tb.sv
module tpwm_top_tb;

    localparam logic [31:0] MAX = 32'hFFFF_FFFF;
    localparam int LIM = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  stat;
    logic        pwm;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    tpwm_top u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .stat_o    (stat),
        .pwm_o     (pwm)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R10: address 0 control, 1 reload, 2 compare, 3 count
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cfg(input logic [31:0] ctrl, input logic [31:0] ld,
                       input logic [31:0] mt, input logic [31:0] ct);
        wr(2'd0, ctrl & 32'hFFFF_FFFE);
        wr(2'd1, ld);
        wr(2'd2, mt);
        wr(2'd3, ct);
        wr(2'd0, ctrl);
    endtask

    // lengths of one full level==act phase then the following other phase
    task automatic measure(input logic act, output int hi, output int lo);
        int n;
        n = 0;
        while (pwm == act && n < LIM) begin @(negedge clk); n++; end
        n = 0;
        while (pwm != act && n < LIM) begin @(negedge clk); n++; end
        hi = 0;
        while (pwm == act && hi < LIM) begin hi++; @(negedge clk); end
        lo = 0;
        while (pwm != act && lo < LIM) begin lo++; @(negedge clk); end
    endtask

    task automatic t_reset;
        chk("R1 pwm after reset", 32'(pwm), 32'd0);
        chk("R1 status after reset", 32'(stat), 32'd0);
    endtask

    task automatic t_preload;
        int bad;
        // R4: preload all-ones minus one, compare mode, period 10
        cfg(32'h9, MAX - 32'd9, MAX - 32'd7, MAX - 32'd1);
        @(negedge clk);
        chk("R4 low after first tick", 32'(pwm), 32'd0);
        @(negedge clk);
        chk("R4 high on second tick", 32'(pwm), 32'd1);
        while (pwm) @(negedge clk);
        wr(2'd0, 32'h8);
        // R4: preload all-ones minus five, first edge on sixth tick
        cfg(32'h9, MAX - 32'd9, MAX - 32'd7, MAX - 32'd5);
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (pwm) bad++;
        end
        chk("R4 low for five ticks", 32'(bad), 32'd0);
        @(negedge clk);
        chk("R4 high on sixth tick", 32'(pwm), 32'd1);
        wr(2'd0, 32'h8);
    endtask

    task automatic t_pwm_basic;
        int hi, lo;
        cfg(32'h9, MAX - 32'd9, MAX - 32'd7, MAX - 32'd1);
        measure(1'b1, hi, lo);
        chk("R3 active ticks 3", 32'(hi), 32'd3);
        chk("R2 R3 inactive ticks 7", 32'(lo), 32'd7);
        chk("R6 status running", 32'(stat), 32'd1);
        wr(2'd0, 32'h8);
    endtask

    task automatic t_pwm_extremes;
        int hi, lo;
        // R2: minimum period 2, active 1
        cfg(32'h9, MAX - 32'd1, MAX - 32'd1, MAX - 32'd1);
        measure(1'b1, hi, lo);
        chk("R2 min period active", 32'(hi), 32'd1);
        chk("R2 min period inactive", 32'(lo), 32'd1);
        // R3: widest pulse, compare one below all-ones
        cfg(32'h9, MAX - 32'd4, MAX - 32'd1, MAX - 32'd1);
        measure(1'b1, hi, lo);
        chk("R3 wide active", 32'(hi), 32'd4);
        chk("R3 wide inactive", 32'(lo), 32'd1);
        wr(2'd0, 32'h8);
    endtask

    task automatic t_prescale;
        int hi, lo;
        // R9: n=1 -> divide by 4, period 3 ticks, active 1 tick
        cfg(32'h39, MAX - 32'd2, MAX - 32'd2, MAX - 32'd1);
        measure(1'b1, hi, lo);
        chk("R9 div4 active", 32'(hi), 32'd4);
        chk("R9 div4 inactive", 32'(lo), 32'd8);
        // R9: n=0 -> divide by 2
        cfg(32'h19, MAX - 32'd2, MAX - 32'd2, MAX - 32'd1);
        measure(1'b1, hi, lo);
        chk("R9 div2 active", 32'(hi), 32'd2);
        chk("R9 div2 inactive", 32'(lo), 32'd4);
        wr(2'd0, 32'h8);
    endtask

    task automatic t_stop;
        int bad;
        cfg(32'h9, MAX - 32'd9, MAX - 32'd7, MAX - 32'd1);
        while (pwm) @(negedge clk);
        while (!pwm) @(negedge clk);
        wr(2'd0, 32'h8);
        chk("R7 status stopped", 32'(stat), 32'd0);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!pwm) bad++;
        end
        chk("R7 output held while stopped", 32'(bad), 32'd0);
        // count froze at the compare value: first tick after restart ends the pulse
        wr(2'd0, 32'h9);
        @(negedge clk);
        chk("R7 resume from held count", 32'(pwm), 32'd0);
        wr(2'd0, 32'h8);
    endtask

    task automatic t_polarity;
        int hi, lo;
        cfg(32'h9, MAX - 32'd9, MAX - 32'd7, MAX - 32'd1);
        wr(2'd0, 32'hB);
        chk("R6 polarity write ignored while running", 32'(stat), 32'd1);
        wr(2'd0, 32'h8);
        wr(2'd0, 32'hA);
        chk("R6 polarity set while stopped", 32'(stat), 32'd2);
        cfg(32'hB, MAX - 32'd9, MAX - 32'd7, MAX - 32'd1);
        measure(1'b0, hi, lo);
        chk("R6 inverted active ticks", 32'(hi), 32'd3);
        chk("R6 inverted inactive ticks", 32'(lo), 32'd7);
        wr(2'd0, 32'hA);
        wr(2'd0, 32'h8);
        chk("R6 polarity cleared", 32'(stat), 32'd0);
    endtask

    task automatic t_toggle_modes;
        int hi, lo, bad;
        logic lvl;
        // R5: code 1 toggles on wrap
        cfg(32'h5, MAX - 32'd3, MAX - 32'd2, MAX - 32'd1);
        measure(1'b1, hi, lo);
        chk("R5 wrap toggle high", 32'(hi), 32'd4);
        chk("R5 wrap toggle low", 32'(lo), 32'd4);
        // R5: code 3 toggles on compare
        cfg(32'hD, MAX - 32'd3, MAX - 32'd2, MAX - 32'd1);
        measure(1'b1, hi, lo);
        chk("R5 compare toggle high", 32'(hi), 32'd4);
        chk("R5 compare toggle low", 32'(lo), 32'd4);
        // R5: code 0 holds the output
        cfg(32'h1, MAX - 32'd3, MAX - 32'd2, MAX - 32'd1);
        lvl = pwm;
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (pwm != lvl) bad++;
        end
        chk("R5 hold code keeps output", 32'(bad), 32'd0);
        wr(2'd0, 32'h8);
    endtask

    task automatic t_no_shadow;
        int hi, lo;
        cfg(32'h9, MAX - 32'd9, MAX - 32'd7, MAX - 32'd1);
        while (pwm) @(negedge clk);
        while (!pwm) @(negedge clk);
        // raise the compare value in the middle of the active phase
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = MAX - 32'd4;
        hi = 1;
        @(negedge clk);
        wr_en = 1'b0;
        while (pwm && hi < LIM) begin hi++; @(negedge clk); end
        lo = 0;
        while (!pwm && lo < LIM) begin lo++; @(negedge clk); end
        chk("R8 active phase lengthened at once", 32'(hi), 32'd6);
        chk("R8 new inactive length", 32'(lo), 32'd4);
        wr(2'd0, 32'h8);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_preload();
        t_pwm_basic();
        t_pwm_extremes();
        t_prescale();
        t_stop();
        t_polarity();
        t_toggle_modes();
        t_no_shadow();
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule